// File: doc/BRIEF.md
# MMU Control and Fault Status Register File

This block is the small register file that sits beside one translation lookaside buffer of a memory management unit. Software reaches it through a numbered register port: it can program the primary and secondary address-space contexts, the translation table base, the tag-access register and two watchpoint registers. Software can also read and clear the fault status, and read the faulting address. The lookup logic next to the block reports two kinds of event. A protection fault carries an address, a user flag, a write flag and a privilege-violation flag. A translation miss carries the virtual page number.

On a fault the block builds a fault status word. If an earlier fault was never cleared, the word is first replaced by an overflow marker. On a miss the block loads the tag-access register with the missing page and the current context. Register 0 is not stored. It is a tag-target value, computed when read, that places the tag-access context above the upper virtual address bits.

The block has two variants, chosen by a parameter. The data variant stores everything and records the faulting address. The instruction variant takes its context from the data variant's primary context through an input. It ignores writes to the context, fault-address and watchpoint slots, and it never records a fault address.

Top module: `mmu_ctlregs`

## Requirements
- R1: After reset every register reads zero. Indices 9 to 15 always read zero, and writes to them have no effect.
- R2: In the data variant, indices 1, 2, 4, 5, 6, 7 and 8 read back the last 64-bit value written. In the instruction variant, indices 3, 5 and 6 are writable. Reads are combinational on `reg_idx`.
- R3: A fault sets the status to a base value ORed with the following bits: bit 0 set, bit 2 = write flag, bit 3 = user flag, bit 7 = privilege-violation flag. When bit 0 was clear, the base is the previous status.
- R4: If status bit 0 is already set when a fault arrives, the base value is 2 (overflow marker). All earlier status bits are discarded.
- R5: In the data variant, a fault loads index 4 with the fault address.
- R6: A write to index 3 with data bit 0 clear zeroes the status. In the data variant it also zeroes index 4. A write with bit 0 set stores the value as given.
- R7: Index 0 reads as ((tag_access[12:0]) << 48) | (tag_access >> 22), so bits 63:61 and 47:42 are zero. Writes to index 0 are ignored.
- R8: A miss loads tag access (index 6) with {page number, context}, where the page number fills bits 63:13 and the context fills bits 12:0. The context is primary-context bits 12:0 in the data variant and `ext_ctx` in the instruction variant.
- R9: The instruction variant ignores writes to indices 0, 1, 2, 4, 7 and 8. Its index 4 stays zero through faults.
- R10: In the same cycle, a fault takes precedence over a write to index 3, and a miss takes precedence over a write to index 6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_idx | input | 4 | Register index for read and write |
| wr_en | input | 1 | Write strobe for the indexed register |
| wr_data | input | 64 | Write data |
| rd_data | output | 64 | Read value of the indexed register |
| fault_valid | input | 1 | Protection fault event |
| fault_addr | input | 64 | Faulting virtual address |
| fault_user | input | 1 | Fault came from user mode |
| fault_write | input | 1 | Fault came from a store |
| fault_priv | input | 1 | Fault was a privilege violation |
| miss_valid | input | 1 | Translation miss event |
| miss_page | input | 51 | Missing virtual page number (address bits 63:13) |
| ext_ctx | input | 13 | Context supplied from the data variant (instruction variant only) |
| pri_ctx | output | 13 | Primary context bits 12:0, for a paired instruction variant |

## Verification
A corrupt status or fault-address register is visible on `rd_data` the cycle after the fault that wrote it. A wrong overflow choice shows as bit 1 missing, or as stale bits that should have been dropped. A wrong tag-access capture after a miss shows up twice on the next read: in index 6, and in the computed index 0. Index 0 therefore exposes context and address errors at once. A broken write mask in the instruction variant shows as a nonzero read of a slot that must stay zero. Every sweep case reads the registers immediately after the event, so such errors show up at once.

// File: rtl/mmu_reg_pkg.sv
package mmu_reg_pkg;
  localparam int IDX_W = 4;
  localparam logic [IDX_W-1:0] IX_TTGT  = 4'd0;
  localparam logic [IDX_W-1:0] IX_PCTX  = 4'd1;
  localparam logic [IDX_W-1:0] IX_SCTX  = 4'd2;
  localparam logic [IDX_W-1:0] IX_STAT  = 4'd3;
  localparam logic [IDX_W-1:0] IX_FADR  = 4'd4;
  localparam logic [IDX_W-1:0] IX_TBASE = 4'd5;
  localparam logic [IDX_W-1:0] IX_TACC  = 4'd6;
  localparam logic [IDX_W-1:0] IX_VWP   = 4'd7;
  localparam logic [IDX_W-1:0] IX_PWP   = 4'd8;
  localparam int N_PLAIN = 6;

  function automatic logic [IDX_W-1:0] plain_slot_idx(input int s);
    case (s)
      0: plain_slot_idx = IX_PCTX;
      1: plain_slot_idx = IX_SCTX;
      2: plain_slot_idx = IX_TBASE;
      3: plain_slot_idx = IX_TACC;
      4: plain_slot_idx = IX_VWP;
      default: plain_slot_idx = IX_PWP;
    endcase
  endfunction
endpackage

// File: rtl/mmu_fault_status.sv
module mmu_fault_status #(
  parameter int DATA_W = 64,
  parameter bit CAPTURE_ADDR = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              fault_valid,
  input  logic [DATA_W-1:0] fault_addr,
  input  logic              fault_user,
  input  logic              fault_write,
  input  logic              fault_priv,
  input  logic              st_wr_en,
  input  logic              far_wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] st_q,
  output logic [DATA_W-1:0] far_q
);
  logic [DATA_W-1:0] st_d, far_d, st_base, st_bits;
  logic              st_en, far_en;

  always_comb begin
    st_base = st_q[0] ? DATA_W'(2) : st_q;
    st_bits = '0;
    st_bits[0] = 1'b1;
    st_bits[2] = fault_write;
    st_bits[3] = fault_user;
    st_bits[7] = fault_priv;
    st_d   = st_q;
    far_d  = far_q;
    st_en  = 1'b0;
    far_en = 1'b0;
    if (fault_valid) begin
      st_en = 1'b1;
      st_d  = st_base | st_bits;
      if (CAPTURE_ADDR) begin
        far_en = 1'b1;
        far_d  = fault_addr;
      end
    end else if (st_wr_en) begin
      st_en = 1'b1;
      if (!wr_data[0]) begin
        st_d = '0;
        if (CAPTURE_ADDR) begin
          far_en = 1'b1;
          far_d  = '0;
        end
      end else begin
        st_d = wr_data;
      end
    end else if (far_wr_en && CAPTURE_ADDR) begin
      far_en = 1'b1;
      far_d  = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= '0;
      far_q <= '0;
    end else begin
      if (st_en)  st_q  <= st_d;
      if (far_en) far_q <= far_d;
    end
  end

  AST_FAULT_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> st_q[0]); // R3
  AST_FAULT_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |=> (st_q[3] == $past(fault_user)) || $past(st_q[3]) && !$past(st_q[0])); // R3
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_valid && st_q[0]) |=> (st_q[1] && !st_q[4])); // R4
  AST_CLEAR_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
    (!fault_valid && st_wr_en && !wr_data[0]) |=> (st_q == '0)); // R6

  generate
    if (CAPTURE_ADDR) begin : g_far_chk
      AST_FAR_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        fault_valid |=> (far_q == $past(fault_addr))); // R5
    end else begin : g_far_idle
      AST_FAR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        far_q == '0); // R9
    end
  endgenerate
endmodule

// File: rtl/mmu_tag_target.sv
module mmu_tag_target #(
  parameter int DATA_W   = 64,
  parameter int CTX_W    = 13,
  parameter int TT_SHIFT = 22,
  parameter int CTX_POS  = 48
) (
  input  logic [DATA_W-1:0] tag_acc,
  output logic [DATA_W-1:0] tgt
);
  logic [DATA_W-1:0] ctx_field;

  always_comb begin
    ctx_field = '0;
    ctx_field[CTX_POS +: CTX_W] = tag_acc[CTX_W-1:0];
    tgt = ctx_field | (tag_acc >> TT_SHIFT);
  end
endmodule

// File: rtl/mmu_ctlregs.sv
module mmu_ctlregs
  import mmu_reg_pkg::*;
#(
  parameter int DATA_W     = 64,
  parameter int CTX_W      = 13,
  parameter int TT_SHIFT   = 22,
  parameter int CTX_POS    = 48,
  parameter bit IS_DATA_MMU = 1'b1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [IDX_W-1:0]    reg_idx,
  input  logic                wr_en,
  input  logic [DATA_W-1:0]   wr_data,
  output logic [DATA_W-1:0]   rd_data,
  input  logic                fault_valid,
  input  logic [DATA_W-1:0]   fault_addr,
  input  logic                fault_user,
  input  logic                fault_write,
  input  logic                fault_priv,
  input  logic                miss_valid,
  input  logic [DATA_W-CTX_W-1:0] miss_page,
  input  logic [CTX_W-1:0]    ext_ctx,
  output logic [CTX_W-1:0]    pri_ctx
);
  localparam int N_IDX = 1 << IDX_W;
  localparam logic [N_IDX-1:0] WR_MASK =
    IS_DATA_MMU ? N_IDX'(16'b0000_0001_1111_1110) : N_IDX'(16'b0000_0000_0110_1000);

  logic [N_IDX-1:0]  idx_wr;
  logic [DATA_W-1:0] plain_q [N_PLAIN];
  logic [DATA_W-1:0] st_q, far_q, tgt, tag_acc_q;
  logic [CTX_W-1:0]  ctx_sel;

  always_comb begin
    idx_wr = '0;
    if (wr_en) idx_wr[reg_idx] = 1'b1;
    idx_wr = idx_wr & WR_MASK;
  end

  assign tag_acc_q = plain_q[3];
  assign pri_ctx   = plain_q[0][CTX_W-1:0];
  assign ctx_sel   = IS_DATA_MMU ? pri_ctx : ext_ctx;

  generate
    for (genvar s = 0; s < N_PLAIN; s++) begin : g_plain
      localparam logic [IDX_W-1:0] SIDX = plain_slot_idx(s);
      logic              en;
      logic [DATA_W-1:0] d;
      if (SIDX == IX_TACC) begin : g_tacc
        always_comb begin
          en = miss_valid || idx_wr[SIDX];
          d  = miss_valid ? {miss_page, ctx_sel} : wr_data;
        end
      end else begin : g_reg
        always_comb begin
          en = idx_wr[SIDX];
          d  = wr_data;
        end
      end
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  plain_q[s] <= '0;
        else if (en) plain_q[s] <= d;
      end
    end
  endgenerate

  mmu_fault_status #(.DATA_W(DATA_W), .CAPTURE_ADDR(IS_DATA_MMU)) u_fstat (
    .clk(clk), .rst_n(rst_n),
    .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_user(fault_user), .fault_write(fault_write), .fault_priv(fault_priv),
    .st_wr_en(idx_wr[IX_STAT]), .far_wr_en(idx_wr[IX_FADR]),
    .wr_data(wr_data), .st_q(st_q), .far_q(far_q)
  );

  mmu_tag_target #(.DATA_W(DATA_W), .CTX_W(CTX_W), .TT_SHIFT(TT_SHIFT),
                   .CTX_POS(CTX_POS)) u_tgt (
    .tag_acc(tag_acc_q), .tgt(tgt)
  );

  always_comb begin
    case (reg_idx)
      IX_TTGT:  rd_data = tgt;
      IX_PCTX:  rd_data = plain_q[0];
      IX_SCTX:  rd_data = plain_q[1];
      IX_STAT:  rd_data = st_q;
      IX_FADR:  rd_data = far_q;
      IX_TBASE: rd_data = plain_q[2];
      IX_TACC:  rd_data = plain_q[3];
      IX_VWP:   rd_data = plain_q[4];
      IX_PWP:   rd_data = plain_q[5];
      default:  rd_data = '0;
    endcase
  end

  AST_MISS_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    miss_valid |=> (tag_acc_q == {$past(miss_page), $past(ctx_sel)})); // R8
  AST_TGT_RO: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && reg_idx == IX_TTGT && !miss_valid) |=> $stable(tag_acc_q)); // R7
  AST_UNUSED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_idx > IX_PWP) |-> (rd_data == '0)); // R1
  AST_TACC_PRIO: assert property (@(posedge clk) disable iff (!rst_n)
    (miss_valid && wr_en && reg_idx == IX_TACC) |=> (tag_acc_q[CTX_W-1:0] == $past(ctx_sel))); // R10
endmodule

// File: tb/mmu_ctlregs_test.sv
module mmu_ctlregs_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [3:0]  reg_idx = '0;
  logic        wr_en = 1'b0;
  logic [63:0] wr_data = '0;
  logic        fault_valid = 1'b0;
  logic [63:0] fault_addr = '0;
  logic        fault_user = 1'b0, fault_write = 1'b0, fault_priv = 1'b0;
  logic        miss_valid = 1'b0;
  logic [50:0] miss_page = '0;
  logic [63:0] rd_d, rd_i;
  logic [12:0] pctx_d, pctx_i;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  mmu_ctlregs #(.IS_DATA_MMU(1'b1)) uut (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_d), .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_user(fault_user), .fault_write(fault_write), .fault_priv(fault_priv),
    .miss_valid(miss_valid), .miss_page(miss_page), .ext_ctx(13'h0), .pri_ctx(pctx_d));

  mmu_ctlregs #(.IS_DATA_MMU(1'b0)) uut_imm (
    .clk(clk), .rst_n(rst_n), .reg_idx(reg_idx), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_i), .fault_valid(fault_valid), .fault_addr(fault_addr),
    .fault_user(fault_user), .fault_write(fault_write), .fault_priv(fault_priv),
    .miss_valid(miss_valid), .miss_page(miss_page), .ext_ctx(pctx_d), .pri_ctx(pctx_i));

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [3:0] idx, output logic [63:0] vd, output logic [63:0] vi);
    @(negedge clk);
    reg_idx = idx;
    #1;
    vd = rd_d;
    vi = rd_i;
  endtask

  task automatic wr(input logic [3:0] idx, input logic [63:0] v);
    @(negedge clk);
    reg_idx = idx; wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic fault(input logic [63:0] a, input logic u, input logic w, input logic p);
    @(negedge clk);
    fault_valid = 1'b1; fault_addr = a; fault_user = u; fault_write = w; fault_priv = p;
    @(negedge clk);
    fault_valid = 1'b0;
  endtask

  task automatic miss(input logic [50:0] pg);
    @(negedge clk);
    miss_valid = 1'b1; miss_page = pg;
    @(negedge clk);
    miss_valid = 1'b0;
  endtask

  function automatic logic [63:0] exp_stat(input logic [63:0] prev, input logic u,
                                          input logic w, input logic p);
    logic [63:0] b;
    b = prev[0] ? 64'd2 : prev;
    return b | 64'd1 | (64'(w) << 2) | (64'(u) << 3) | (64'(p) << 7);
  endfunction

  function automatic logic [63:0] exp_tgt(input logic [63:0] ta);
    return (64'(ta[12:0]) << 48) | (ta >> 22);
  endfunction

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin : main
    logic [63:0] vd, vi, prev, ta, e;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, all indices zero
    for (int i = 0; i < 16; i++) begin
      rd(4'(i), vd, vi);
      chk("R1 reset data", vd, 64'h0);
      chk("R1 reset instr", vi, 64'h0);
    end

    // R2 / R9: write sweep over indices 1..8 (except 3) with distinct patterns
    for (int i = 1; i <= 8; i++) begin
      if (i != 3) wr(4'(i), 64'hA5A5_0000_0000_0000 | (64'(i) * 64'h1111_1111));
    end
    for (int i = 1; i <= 8; i++) begin
      if (i != 3) begin
        e = 64'hA5A5_0000_0000_0000 | (64'(i) * 64'h1111_1111);
        rd(4'(i), vd, vi);
        chk("R2 data rw", vd, e);
        if (i == 5 || i == 6) chk("R2 instr rw", vi, e);
        else chk("R9 instr ignored", vi, 64'h0);
      end
    end

    // R1: unused indices ignore writes
    for (int i = 9; i < 16; i++) begin
      wr(4'(i), 64'hFFFF_FFFF_FFFF_FFFF);
      rd(4'(i), vd, vi);
      chk("R1 unused data", vd, 64'h0);
      chk("R1 unused instr", vi, 64'h0);
    end

    // R7: tag target across tag-access patterns, index 0 read-only
    for (int k = 0; k < 6; k++) begin
      ta = 64'h9E37_79B9_7F4A_7C15 * 64'(k + 1);
      wr(4'd6, ta);
      wr(4'd0, 64'hDEAD_BEEF_DEAD_BEEF);
      rd(4'd0, vd, vi);
      chk("R7 tgt data", vd, exp_tgt(ta));
      chk("R7 tgt instr", vi, exp_tgt(ta));
      rd(4'd6, vd, vi);
      chk("R7 write ignored", vd, ta);
    end

    // R3/R4/R5/R6: near-exhaustive fault sweep
    for (int pv = 0; pv < 2; pv++) begin
      for (int f = 0; f < 8; f++) begin
        wr(4'd3, 64'h0);
        prev = 64'h0;
        if (pv == 1) begin
          wr(4'd3, 64'h31);
          prev = 64'h31;
        end
        fault(64'hFFFF_8000_0000_0000 | 64'(f * 8192 + pv), f[0], f[1], f[2]);
        e = exp_stat(prev, f[0], f[1], f[2]);
        rd(4'd3, vd, vi);
        chk(pv ? "R4 overflow data" : "R3 status data", vd, e);
        chk(pv ? "R4 overflow instr" : "R3 status instr", vi, e);
        rd(4'd4, vd, vi);
        chk("R5 fault addr", vd, 64'hFFFF_8000_0000_0000 | 64'(f * 8192 + pv));
        chk("R9 instr fault addr", vi, 64'h0);
      end
    end

    // R6: clear write zeroes status and fault address
    wr(4'd3, 64'h8E);
    rd(4'd3, vd, vi);
    chk("R6 clear status data", vd, 64'h0);
    chk("R6 clear status instr", vi, 64'h0);
    rd(4'd4, vd, vi);
    chk("R6 clear fault addr", vd, 64'h0);
    wr(4'd3, 64'h1234_0000_0000_0085);
    rd(4'd3, vd, vi);
    chk("R6 store set data", vd, 64'h1234_0000_0000_0085);
    chk("R6 store set instr", vi, 64'h1234_0000_0000_0085);

    // R8: miss with primary context, instr variant uses ext_ctx from data
    wr(4'd1, 64'h0000_0000_0000_1ABC);
    miss(51'h2_3456_789A_BCDE);
    rd(4'd6, vd, vi);
    chk("R8 miss data", vd, {51'h2_3456_789A_BCDE, 13'h1ABC});
    chk("R8 miss instr", vi, {51'h2_3456_789A_BCDE, 13'h1ABC});
    rd(4'd0, vd, vi);
    chk("R8 miss tgt", vd, exp_tgt({51'h2_3456_789A_BCDE, 13'h1ABC}));
    wr(4'd1, 64'hFFFF_0000_0000_0007);
    miss(51'h7_FFFF_FFFF_FFFF);
    rd(4'd6, vd, vi);
    chk("R8 miss ctx2", vd, {51'h7_FFFF_FFFF_FFFF, 13'h0007});
    chk("R8 miss ctx2 instr", vi, {51'h7_FFFF_FFFF_FFFF, 13'h0007});

    // R10: fault beats status write; miss beats tag-access write
    wr(4'd3, 64'h0);
    @(negedge clk);
    reg_idx = 4'd3; wr_en = 1'b1; wr_data = 64'h0;
    fault_valid = 1'b1; fault_addr = 64'h4000; fault_user = 1'b1;
    fault_write = 1'b0; fault_priv = 1'b0;
    @(negedge clk);
    wr_en = 1'b0; fault_valid = 1'b0;
    rd(4'd3, vd, vi);
    chk("R10 fault over write", vd, 64'h9);
    @(negedge clk);
    reg_idx = 4'd6; wr_en = 1'b1; wr_data = 64'h5555_5555_5555_5555;
    miss_valid = 1'b1; miss_page = 51'h1;
    @(negedge clk);
    wr_en = 1'b0; miss_valid = 1'b0;
    rd(4'd6, vd, vi);
    chk("R10 miss over write", vd, {51'h1, 13'h0007});

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule